// File: doc/BRIEF.md
# Accumulator Cut with Round and Saturate

This unit takes a 64-bit signed accumulator value and extracts a 32-bit signed word from it at a position chosen by a cut operand. The cut operand selects the alignment. A positive cut moves the window toward the high end of the accumulator. A negative cut first shifts the accumulator right arithmetically by the cut's magnitude.

When low-order bits fall off the bottom of the window, the result is rounded half-up on the most significant lost bit. Any value that will not fit in 32 signed bits is clamped to the nearest end of the signed range.

Issue a request by raising the valid strobe together with the operands. The result and its valid flag appear registered on the next clock edge. The output register holds its contents between requests.

Top module: `acc_cut`

## Requirements
- R1: Only bits [6:0] of `cut_i` are used, read as a two's-complement value c in -64..63. Bits [31:7] have no effect on the result.
- R2: For c < 0, the accumulator is first arithmetically shifted right by -c and then handled as c = 0. c = -64 gives the same result as a right shift by 63.
- R3: For 0 <= c < 32, the value is the accumulator shifted right arithmetically by (32 - c). It is increased by one when accumulator bit (31 - c) is 1 and the shifted value is below 0x7FFFFFFF.
- R4: For c >= 32, the value is the accumulator shifted left by (c - 32). With c = 32, an accumulator that fits in 32 signed bits is returned unchanged.
- R5: A value above 2^31 - 1 yields `res_o` = 0x7FFFFFFF.
- R6: A value below -2^31 yields `res_o` = 0x80000000.
- R7: A non-negative accumulator never yields a negative result, and a negative accumulator never yields a positive result. A zero accumulator yields zero.
- R8: `valid_o` equals `valid_i` delayed by one clock. The result of a request is on `res_o` in the cycle after the edge that samples `valid_i` high.
- R9: While `valid_i` is low, `res_o` keeps its last value whatever `acc_i` and `cut_i` carry.
- R10: When `rst_ni` is low, `res_o` is cleared to 0 and `valid_o` to 0, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| acc_i | input | 64 | Signed accumulator value |
| cut_i | input | 32 | Cut operand; low 7 bits used, signed |
| valid_o | output | 1 | Result valid, one cycle after the request |
| res_o | output | 32 | Rounded and saturated signed result |

## Verification
The only state in this unit is the output register, and each request overwrites it. A wrong shift amount, a wrong rounding bit or a wrong clamp decision therefore shows up on `res_o` in the cycle right after the request. Errors near the boundaries tend to show up as an off-by-one value, a wrong sign, or a clamp to the wrong end. The random stimulus mixes small and full-width accumulators with every cut value, so both the rounding path and the saturation path are exercised. A broken hold or valid path shows up as `res_o` changing, or `valid_o` staying high, during idle cycles.

// File: rtl/acc_cut_pkg.sv
package acc_cut_pkg;
  localparam int unsigned ACC_W_DEF = 64;
  localparam int unsigned RES_W_DEF = 32;
  localparam int unsigned OPND_W_DEF = 32;
  localparam int unsigned CUT_W_DEF = 7;

  typedef enum logic [1:0] {
    WIN_LOW  = 2'd0,  // window below result width: shift right and round
    WIN_HIGH = 2'd1   // window at or above result width: shift left
  } win_mode_e;
endpackage

// File: rtl/acc_cut_prescale.sv
module acc_cut_prescale #(
  parameter int unsigned ACC_W = 64,
  parameter int unsigned CUT_W = 7
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic        [CUT_W-1:0] cut_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic        [CUT_W-2:0] cut_o
);
  logic             neg;
  logic [CUT_W-1:0] mag;

  assign neg = cut_i[CUT_W-1];
  // two's complement magnitude; the most negative code maps to 2^(CUT_W-1)
  assign mag = (~cut_i) + {{(CUT_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (neg) begin
      acc_o = acc_i >>> mag;
      cut_o = '0;
    end else begin
      acc_o = acc_i;
      cut_o = cut_i[CUT_W-2:0];
    end
  end
endmodule

// File: rtl/acc_cut_window.sv
module acc_cut_window
  import acc_cut_pkg::*;
#(
  parameter int unsigned ACC_W = 64,
  parameter int unsigned RES_W = 32,
  parameter int unsigned CUT_W = 7
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic        [CUT_W-2:0] cut_i,
  output logic signed [ACC_W-1:0] lower_o,
  output logic signed [ACC_W-1:0] upper_o
);
  localparam int unsigned SW = CUT_W;
  localparam logic signed [ACC_W-1:0] RES_MAX =
    {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};

  win_mode_e mode;

  logic [SW-1:0] rsh, rbi, lsh, ush;
  logic signed [ACC_W-1:0] shr, lo_val, lo_up, hi_val, hi_up;
  logic [ACC_W-1:0] rb_vec;
  logic rbit, inc;

  assign mode = (SW'(cut_i) < SW'(RES_W)) ? WIN_LOW : WIN_HIGH;

  // low window: drop (RES_W - cut) bits, round half-up on the top dropped bit
  assign rsh    = SW'(RES_W) - SW'(cut_i);
  assign rbi    = SW'(RES_W - 1) - SW'(cut_i);
  assign shr    = acc_i >>> rsh;
  assign rb_vec = acc_i >> rbi;
  assign rbit   = rb_vec[0];
  assign inc    = rbit && (shr < RES_MAX);
  assign lo_val = shr + $signed({{(ACC_W-1){1'b0}}, inc});
  assign lo_up  = lo_val >>> (RES_W - 1);

  // high window: scale up, keep everything above the result's top bit for the clamp
  assign lsh    = SW'(cut_i) - SW'(RES_W);
  assign ush    = SW'(ACC_W - 1) - SW'(cut_i);
  assign hi_val = acc_i <<< lsh;
  assign hi_up  = acc_i >>> ush;

  always_comb begin
    unique case (mode)
      WIN_LOW: begin
        lower_o = lo_val;
        upper_o = lo_up;
      end
      default: begin
        lower_o = hi_val;
        upper_o = hi_up;
      end
    endcase
  end
endmodule

// File: rtl/acc_cut_clamp.sv
module acc_cut_clamp #(
  parameter int unsigned ACC_W = 64,
  parameter int unsigned RES_W = 32
) (
  input  logic signed [ACC_W-1:0] lower_i,
  input  logic signed [ACC_W-1:0] upper_i,
  output logic signed [RES_W-1:0] res_o
);
  logic sat_pos, sat_neg;

  // upper holds the bits above the result's sign bit: must be all 0s or all 1s
  assign sat_pos = !upper_i[ACC_W-1] && (|upper_i);
  assign sat_neg =  upper_i[ACC_W-1] && !(&upper_i);

  always_comb begin
    if (sat_pos)      res_o = {1'b0, {(RES_W-1){1'b1}}};
    else if (sat_neg) res_o = {1'b1, {(RES_W-1){1'b0}}};
    else              res_o = lower_i[RES_W-1:0];
  end
endmodule

// File: rtl/acc_cut.sv
module acc_cut
  import acc_cut_pkg::*;
#(
  parameter int unsigned ACC_W  = ACC_W_DEF,
  parameter int unsigned RES_W  = RES_W_DEF,
  parameter int unsigned OPND_W = OPND_W_DEF,
  parameter int unsigned CUT_W  = CUT_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic        [OPND_W-1:0] cut_i,
  output logic                     valid_o,
  output logic signed [RES_W-1:0]  res_o
);
  logic signed [ACC_W-1:0] acc_pre, lower, upper;
  logic        [CUT_W-2:0] cut_pre;
  logic signed [RES_W-1:0] res_d;

  acc_cut_prescale #(.ACC_W(ACC_W), .CUT_W(CUT_W)) u_pre (
    .acc_i (acc_i),
    .cut_i (cut_i[CUT_W-1:0]),
    .acc_o (acc_pre),
    .cut_o (cut_pre)
  );

  acc_cut_window #(.ACC_W(ACC_W), .RES_W(RES_W), .CUT_W(CUT_W)) u_win (
    .acc_i   (acc_pre),
    .cut_i   (cut_pre),
    .lower_o (lower),
    .upper_o (upper)
  );

  acc_cut_clamp #(.ACC_W(ACC_W), .RES_W(RES_W)) u_clamp (
    .lower_i (lower),
    .upper_i (upper),
    .res_o   (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end
endmodule

// File: rtl/acc_cut_chk.sv
module acc_cut_chk #(
  parameter int unsigned ACC_W  = 64,
  parameter int unsigned RES_W  = 32,
  parameter int unsigned OPND_W = 32,
  parameter int unsigned CUT_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [ACC_W-1:0]  acc_i,
  input logic [OPND_W-1:0] cut_i,
  input logic              valid_o,
  input logic [RES_W-1:0]  res_o
);
  logic acc_fits;
  assign acc_fits = (&acc_i[ACC_W-1:RES_W-1]) || !(|acc_i[ACC_W-1:RES_W-1]);

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R8
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));  // R9
  AST_SIGN_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !acc_i[ACC_W-1]) |=> !res_o[RES_W-1]);  // R7
  AST_SIGN_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_i[ACC_W-1]) |=> (res_o[RES_W-1] || res_o == '0));  // R7
  AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_i == '0) |=> res_o == '0);  // R7
  AST_UNIT_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cut_i[CUT_W-1:0] == CUT_W'(RES_W) && acc_fits)
      |=> res_o == $past(acc_i[RES_W-1:0]));  // R4
endmodule

bind acc_cut acc_cut_chk #(
  .ACC_W(ACC_W), .RES_W(RES_W), .OPND_W(OPND_W), .CUT_W(CUT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .acc_i   (acc_i),
  .cut_i   (cut_i),
  .valid_o (valid_o),
  .res_o   (res_o)
);

// File: tb/tb_acc_cut.sv
module tb_acc_cut;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic signed [63:0] acc_i = '0;
  logic        [31:0] cut_i = '0;
  logic               valid_o;
  logic signed [31:0] res_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  acc_cut dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .acc_i(acc_i), .cut_i(cut_i), .valid_o(valid_o), .res_o(res_o)
  );

  // wide reference: sign-extend to 128 bits, scale by 2^c, take bits [63:32]
  function automatic logic signed [31:0] ref_cut(input logic signed [63:0] a,
                                                 input logic [31:0] op);
    int c;
    logic signed [127:0] e, s, q;
    c = int'($signed(op[6:0]));
    e = a;
    if (c < 0) begin
      e = e >>> (-c);
      c = 0;
    end
    s = e <<< c;
    q = s >>> 32;
    if (s[31] && q < 128'sh7fffffff) q = q + 128'sd1;
    if (q > 128'sh7fffffff) return 32'h7fffffff;
    if (q < -128'sh80000000) return 32'h80000000;
    return q[31:0];
  endfunction

  function automatic string tag_of(input logic signed [63:0] a, input logic [31:0] op);
    int c;
    logic signed [31:0] r;
    c = int'($signed(op[6:0]));
    r = ref_cut(a, op);
    if (r == 32'sh7fffffff && a > 0) return "R5";
    if (r == 32'sh80000000) return "R6";
    if (c < 0) return "R2";
    if (c < 32) return "R3";
    return "R4";
  endfunction

  task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // one request; result sampled on the following falling edge
  task automatic run(input string tag, input logic signed [63:0] a, input logic [31:0] op);
    logic signed [31:0] exp;
    exp = ref_cut(a, op);
    @(negedge clk_i);
    acc_i = a; cut_i = op; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check32(tag, res_o, exp);
    check32("R8", {31'd0, valid_o}, 32'd1);
    if (a >= 0 && res_o[31]) check32("R7", res_o, exp);
    if (a < 0 && res_o > 0) check32("R7", res_o, exp);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic signed [31:0] held;
    void'($urandom(32'd5150));
    #10;
    check32("R10", res_o, 32'd0);
    check32("R10", {31'd0, valid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    run("R3", 64'sh0000_0001_8000_0000, 32'd0);   // round up
    run("R3", 64'sh0000_0001_7fff_ffff, 32'd0);   // no round
    run("R3", -64'sd1, 32'd0);                    // -1 rounds to 0
    run("R3", 64'sh7fff_ffff_8000_0000, 32'd0);   // no increment past max
    run("R2", -64'sd1000, 32'h7f);                // c = -1
    run("R2", 64'sh8000_0000_0000_0000, 32'h40);  // c = -64
    run("R2", 64'sh7fff_ffff_ffff_ffff, 32'h40);
    run("R4", 64'sh0000_0000_1234_5678, 32'd32);
    run("R4", -64'sd5, 32'd32);
    run("R4", 64'sh0000_0000_0000_0003, 32'd62);
    run("R5", 64'sh0000_0000_0000_0001, 32'd63);
    run("R6", -64'sd2, 32'd63);
    run("R6", 64'sh8000_0000_0000_0000, 32'd0);
    run("R5", 64'sh0000_0000_8000_0000, 32'd32);
    run("R1", 64'sh0000_0003_0000_0000, 32'hffff_ff81);  // c = -127? low7=0x01
    run("R1", 64'sh0000_0000_0012_3456, 32'h5555_5520);
    run("R7", 64'sd0, 32'd17);

    // idle cycles must not disturb the result
    held = res_o;
    @(negedge clk_i);
    acc_i = 64'sh0123_4567_89ab_cdef; cut_i = 32'd40;
    @(negedge clk_i);
    check32("R9", res_o, held);
    check32("R8", {31'd0, valid_o}, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      logic signed [63:0] a;
      logic [31:0] op;
      a = {$urandom, $urandom};
      case ($urandom % 4)
        0: a = a >>> ($urandom % 64);
        1: a = a >>> 24;
        2: a = a >>> 40;
        default: ;
      endcase
      op = $urandom;
      run(tag_of(a, op), a, op);
    end

    // asynchronous reset mid-cycle
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1 check32("R10", res_o, 32'd0);
    check32("R10", {31'd0, valid_o}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule